// File: doc/BRIEF.md
# Even/Odd Pixel Black-Level Offset Corrector

This block sits after the converter of a two-channel interleaved pixel sampler. Pixels arrive one per clock as 10-bit codes. Neighbouring pixels come alternately from two sampling channels that have slightly different offsets. During an optical-black calibration window, the block learns each channel's black level. Each channel has its own leaky-average tracker, and the pixel's parity picks which tracker is updated. After the window, the block adds a per-channel offset to every pixel, so that black from either channel lands on one programmable black target.

Correction costs two extra clock cycles over the bypass path. A status output reports these extra cycles. A blanking input forces the output code to zero. The calibration strobe can be used active-high or active-low.

Top module: `eoc_offset_corr`

## Requirements
- R1: After synchronous reset, `pix_out` and `extra_lat` are 0, the parity toggle points to channel 0, and both channel estimates are 0.
- R2: The channel toggles on every pixel: a pixel with parity 0 uses channel 0 and parity 1 uses channel 1. The first pixel of each calibration window (the first cycle in which the strobe is active after a cycle in which it was not) is forced to channel 0.
- R3: A channel accumulator `acc` (PIX_W+SHIFT bits, SHIFT=3 by default) changes only on a pixel of that channel inside the calibration window. The update is acc <= acc - floor(acc/2^SHIFT) + pixel. The estimate is floor(acc/2^SHIFT). Pixels outside the window leave both estimates unchanged.
- R4: `level_sel` selects the black target, sampled together with each pixel: 2'b00 gives 32, 2'b01 gives 48, 2'b10 gives 64, 2'b11 gives 16.
- R5: In correction mode the output is pixel + target - estimate of the pixel's channel, saturated to the range 0..1023.
- R6: `corr_off` is an active-low enable. With `corr_off`=0, a pixel appears at `pix_out` 3 clock edges after it is presented. With `corr_off`=1, the raw pixel appears after 1 edge.
- R7: A pixel presented with `blank_n`=0 comes out as 0 in either mode, with the latency of that mode.
- R8: With `clamp_act_high`=1 the calibration window is the time when `clamp_strobe` is 1. With `clamp_act_high`=0 it is the time when `clamp_strobe` is 0.
- R9: One edge after `corr_off` is sampled, `extra_lat` reads 2 if correction is on and 0 in bypass.
- R10: Suppose a window holds at least 128 pixels of each channel at constant black levels within 0..1023. Afterwards, black input from both channels comes out exactly at the target, so the residual mismatch between channels is 0 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_in | input | 10 | Incoming pixel code |
| clamp_strobe | input | 1 | Optical-black calibration strobe |
| clamp_act_high | input | 1 | Strobe polarity: 1 active-high, 0 active-low |
| blank_n | input | 1 | Blanking, active low: output forced to zero |
| level_sel | input | 2 | Black target select code |
| corr_off | input | 1 | 0 correction in use, 1 bypass |
| pix_out | output | 10 | Corrected (or bypassed) pixel code |
| extra_lat | output | 2 | Extra cycles added by the selected mode |

## Verification
The hardest situation to reach is a calibration window that opens after an odd number of free-running pixels. Only then does the forced parity restart change which channel learns which level. The stimulus places one or three stray pixels before each window and feeds different black levels to the two channels. A wrong channel assignment then shows up as swapped offsets on every later pixel.

The estimates have to settle fully before exact outputs can be predicted. The windows are therefore 256 pixels long. The saturation cases are reached by pairing a low or high input with targets that push the sum past either rail.

// File: rtl/eoc_pkg.sv
package eoc_pkg;
  localparam int TGT_W = 7;

  // black target in LSB for each select code
  function automatic logic [TGT_W-1:0] black_target(input logic [1:0] sel);
    case (sel)
      2'b00:   return TGT_W'(32);
      2'b01:   return TGT_W'(48);
      2'b10:   return TGT_W'(64);
      default: return TGT_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/eoc_parity.sv
module eoc_parity (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic act_high,
  output logic cal_act,
  output logic cal_start,
  output logic par
);
  logic cal_q;
  logic par_q;

  assign cal_act   = act_high ? strobe : ~strobe;
  assign cal_start = cal_act & ~cal_q;
  assign par       = cal_start ? 1'b0 : par_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q <= 1'b0;
      par_q <= 1'b0;
    end else begin
      cal_q <= cal_act;
      par_q <= ~par;
    end
  end
endmodule

// File: rtl/eoc_tracker.sv
module eoc_tracker #(
  parameter int PW    = 10,
  parameter int SHIFT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [PW-1:0] sample,
  output logic [PW-1:0] est
);
  localparam int ACC_W = PW + SHIFT;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_nxt;

  assign est     = acc_q[ACC_W-1:SHIFT];
  assign acc_nxt = acc_q - (acc_q >> SHIFT) + {{SHIFT{1'b0}}, sample};

  always_ff @(posedge clk) begin
    if (rst)      acc_q <= '0;
    else if (upd) acc_q <= acc_nxt;
  end
endmodule

// File: rtl/eoc_apply.sv
module eoc_apply #(
  parameter int PW = 10,
  parameter int TW = 7
) (
  input  logic [PW-1:0] pix,
  input  logic [TW-1:0] tgt,
  input  logic [PW-1:0] est,
  output logic [PW-1:0] res
);
  localparam int SW = PW + 2;
  localparam logic signed [SW-1:0] MAXV = {2'b00, {PW{1'b1}}};

  logic signed [SW-1:0] sum;

  assign sum = $signed({2'b00, pix}) + $signed({{(SW-TW){1'b0}}, tgt})
             - $signed({2'b00, est});

  always_comb begin
    if (sum < 0)         res = '0;
    else if (sum > MAXV) res = '1;
    else                 res = sum[PW-1:0];
  end
endmodule

// File: rtl/eoc_offset_corr.sv
module eoc_offset_corr
  import eoc_pkg::*;
#(
  parameter int PIX_W = 10,
  parameter int SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             clamp_strobe,
  input  logic             clamp_act_high,
  input  logic             blank_n,
  input  logic [1:0]       level_sel,
  input  logic             corr_off,
  output logic [PIX_W-1:0] pix_out,
  output logic [1:0]       extra_lat
);
  localparam int NCH = 2;

  logic cal_act, cal_start, par;
  logic [PIX_W-1:0] est_w [NCH];

  eoc_parity u_par (
    .clk      (clk),
    .rst      (rst),
    .strobe   (clamp_strobe),
    .act_high (clamp_act_high),
    .cal_act  (cal_act),
    .cal_start(cal_start),
    .par      (par)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_trk
    eoc_tracker #(.PW(PIX_W), .SHIFT(SHIFT)) u_trk (
      .clk   (clk),
      .rst   (rst),
      .upd   (cal_act && (par == 1'(ch))),
      .sample(pix_in),
      .est   (est_w[ch])
    );
  end

  // stage A: pixel with its channel, blanking and target
  logic [PIX_W-1:0] a_pix;
  logic             a_par, a_blank_n;
  logic [TGT_W-1:0] a_tgt;
  // stage B: corrected value
  logic [PIX_W-1:0] b_pix;
  logic             b_blank_n;
  logic [PIX_W-1:0] corr_val;

  eoc_apply #(.PW(PIX_W), .TW(TGT_W)) u_app (
    .pix(a_pix),
    .tgt(a_tgt),
    .est(est_w[a_par]),
    .res(corr_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_pix     <= '0;
      a_par     <= 1'b0;
      a_blank_n <= 1'b0;
      a_tgt     <= '0;
      b_pix     <= '0;
      b_blank_n <= 1'b0;
      pix_out   <= '0;
      extra_lat <= 2'd0;
    end else begin
      a_pix     <= pix_in;
      a_par     <= par;
      a_blank_n <= blank_n;
      a_tgt     <= black_target(level_sel);
      b_pix     <= corr_val;
      b_blank_n <= a_blank_n;
      if (corr_off) pix_out <= blank_n ? pix_in : '0;
      else          pix_out <= b_blank_n ? b_pix : '0;
      extra_lat <= corr_off ? 2'd0 : 2'd2;
    end
  end
endmodule

// File: rtl/eoc_chk.sv
module eoc_chk #(
  parameter int PW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          corr_off,
  input logic          blank_n,
  input logic [PW-1:0] pix_in,
  input logic [PW-1:0] pix_out,
  input logic [1:0]    extra_lat,
  input logic          cal_act,
  input logic          cal_start,
  input logic          par,
  input logic [PW-1:0] est0,
  input logic [PW-1:0] est1
);
  p_par_restart_r2: assert property (@(posedge clk) disable iff (rst)
    cal_start |=> par);

  p_est_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cal_act |=> ($stable(est0) && $stable(est1)));

  p_bypass_raw_r6: assert property (@(posedge clk) disable iff (rst)
    (corr_off && blank_n) |=> pix_out == $past(pix_in));

  p_blank_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (corr_off && !blank_n) |=> pix_out == '0);

  p_lat_bypass_r9: assert property (@(posedge clk) disable iff (rst)
    corr_off |=> extra_lat == 2'd0);

  p_lat_corr_r9: assert property (@(posedge clk) disable iff (rst)
    !corr_off |=> extra_lat == 2'd2);
endmodule

bind eoc_offset_corr eoc_chk #(.PW(PIX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .corr_off (corr_off),
  .blank_n  (blank_n),
  .pix_in   (pix_in),
  .pix_out  (pix_out),
  .extra_lat(extra_lat),
  .cal_act  (cal_act),
  .cal_start(cal_start),
  .par      (par),
  .est0     (est_w[0]),
  .est1     (est_w[1])
);

// File: tb/test_eoc_offset_corr.sv
module test_eoc_offset_corr;
  localparam int PW = 10;
  localparam int SH = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [PW-1:0] pix_in;
  logic          clamp_strobe, clamp_act_high, blank_n, corr_off;
  logic [1:0]    level_sel;
  logic [PW-1:0] pix_out;
  logic [1:0]    extra_lat;

  eoc_offset_corr #(.PIX_W(PW), .SHIFT(SH)) i_eoc_offset_corr (
    .clk(clk), .rst(rst), .pix_in(pix_in), .clamp_strobe(clamp_strobe),
    .clamp_act_high(clamp_act_high), .blank_n(blank_n), .level_sel(level_sel),
    .corr_off(corr_off), .pix_out(pix_out), .extra_lat(extra_lat)
  );

  always #2 clk = ~clk;

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 0;
  int    he [8];
  bit    hv [8];
  string ht [8];
  int    cyc = 0;
  int    macc [2];
  bit    mpar, mprev;

  function automatic int tgt_of(input logic [1:0] s);
    case (s)
      2'b00: return 32;
      2'b01: return 48;
      2'b10: return 64;
      default: return 16;
    endcase
  endfunction

  function automatic int sat(input int v);
    if (v < 0) return 0;
    if (v > 1023) return 1023;
    return v;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 8; i++) hv[i] = 0;
  endtask

  // one pixel per call; compares the output due now, then drives the next pixel
  task automatic step(input int p, input bit s, input bit bn, input string tag);
    int  lat;
    int  slot;
    bit  ca;
    bit  cp;
    int  e;
    lat  = corr_off ? 1 : 3;
    slot = ((cyc - lat) % 8 + 8) % 8;
    if (hv[slot]) chk(ht[slot], int'(pix_out), he[slot]);
    pix_in       = p[PW-1:0];
    clamp_strobe = s;
    blank_n      = bn;
    ca = clamp_act_high ? s : !s;
    cp = (ca && !mprev) ? 1'b0 : mpar;
    if (ca) macc[cp] = macc[cp] - (macc[cp] >> SH) + p;
    if (!bn)           e = 0;
    else if (corr_off) e = p;
    else               e = sat(p + tgt_of(level_sel) - (macc[cp] >> SH));
    mpar  = !cp;
    mprev = ca;
    he[cyc % 8] = e;
    hv[cyc % 8] = 1;
    ht[cyc % 8] = tag;
    cyc++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_off(input bit v);
    corr_off = v;
    clear_hist();
  endtask

  task automatic t_reset();
    rst = 1; pix_in = '0; clamp_strobe = 0; clamp_act_high = 1;
    blank_n = 1; level_sel = 2'b00; corr_off = 0;
    macc[0] = 0; macc[1] = 0; mpar = 0; mprev = 0;
    clear_hist();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pix_out", int'(pix_out), 0);
    chk("R1 reset extra_lat", int'(extra_lat), 0);
    rst = 0;
    // zero estimates: pixel + 32 right after reset
    step(100, 0, 1, "R1");
    step(200, 0, 1, "R1");
    step(300, 0, 1, "R1");
    repeat (3) step(0, 0, 1, "R1");
  endtask

  task automatic t_calibrate();
    level_sel = 2'b00;
    step(500, 0, 1, "R2");             // stray pixel leaves the toggle odd
    for (int i = 0; i < 256; i++) step((i % 2 == 0) ? 40 : 20, 1, 1, "R3");
    for (int i = 0; i < 8; i++) step((i % 2 == 0) ? 40 : 20, 0, 1, "R10");
    for (int i = 0; i < 6; i++) step(100, 0, 1, "R5");
    // second window after three stray pixels, channels swapped in level
    for (int i = 0; i < 3; i++) step(700, 0, 1, "R2");
    for (int i = 0; i < 256; i++) step((i % 2 == 0) ? 20 : 40, 1, 1, "R2");
    for (int i = 0; i < 8; i++) step((i % 2 == 0) ? 20 : 40, 0, 1, "R10");
    for (int i = 0; i < 4; i++) step(100, 0, 1, "R2");
    // restore original levels for later tasks
    step(0, 0, 1, "R2");
    for (int i = 0; i < 256; i++) step((i % 2 == 0) ? 40 : 20, 1, 1, "R3");
    repeat (3) step(0, 0, 1, "R3");
  endtask

  task automatic t_levels();
    for (int s = 1; s < 4; s++) begin
      level_sel = 2'(s);
      for (int i = 0; i < 4; i++) step(200 + i, 0, 1, "R4");
    end
    level_sel = 2'b00;
    repeat (3) step(0, 0, 1, "R4");
  endtask

  task automatic t_saturate();
    level_sel = 2'b11;
    for (int i = 0; i < 4; i++) step(5, 0, 1, "R5");
    level_sel = 2'b10;
    for (int i = 0; i < 4; i++) step(1000, 0, 1, "R5");
    level_sel = 2'b00;
    for (int i = 0; i < 2; i++) step(1023, 0, 1, "R5");
    repeat (3) step(0, 0, 1, "R5");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 20; i++) step(900, 0, 1, "R3");
    for (int i = 0; i < 6; i++) step(40, 0, 1, "R3");
  endtask

  task automatic t_polarity();
    clamp_strobe = 1;
    clamp_act_high = 0;
    step(0, 1, 1, "R8");
    for (int i = 0; i < 256; i++) step((i % 2 == 0) ? 60 : 70, 0, 1, "R8");
    for (int i = 0; i < 8; i++) step((i % 2 == 0) ? 60 : 70, 1, 1, "R8");
    for (int i = 0; i < 4; i++) step(100, 1, 1, "R8");
    clamp_strobe = 0;
    clamp_act_high = 1;
    repeat (3) step(0, 0, 1, "R8");
  endtask

  task automatic t_blank();
    for (int i = 0; i < 6; i++) step(300, 0, (i % 2 == 1), "R7");
    set_off(1);
    for (int i = 0; i < 6; i++) step(300 + i, 0, (i % 3 != 0), "R7");
    set_off(0);
    repeat (3) step(0, 0, 1, "R7");
  endtask

  task automatic t_bypass();
    set_off(1);
    step(7, 0, 1, "R6");
    chk("R9 bypass extra_lat", int'(extra_lat), 0);
    step(513, 0, 1, "R6");
    step(1023, 0, 1, "R6");
    step(0, 0, 1, "R6");
    step(1, 0, 1, "R6");
    set_off(0);
    step(50, 0, 1, "R6");
    chk("R9 correct extra_lat", int'(extra_lat), 2);
    for (int i = 0; i < 5; i++) step(60 + i, 0, 1, "R6");
  endtask

  initial begin
    t_reset();
    t_calibrate();
    t_levels();
    t_saturate();
    t_hold();
    t_polarity();
    t_blank();
    t_bypass();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule